// File: doc/BRIEF.md
# Four-Bit Adder with Hex Digit Readout

This block adds two 4-bit operands and a carry-in bit taken straight from board slide switches. The addition runs through a chain of four one-bit full-adder stages, each stage passing its carry to the next. The carry-in input lets the block sit behind an earlier adder stage.

The 4-bit result appears as one hexadecimal character on the leftmost digit of a four-digit common-anode seven-segment display. The other three digits stay dark. When the addition overflows four bits, the decimal point of that same digit lights. The raw sum and carry-out are also brought out as ports so they can be observed directly.

The block has no clock or state. Every output follows the switches combinationally.

Top module: `adder_hex_disp`

## Requirements
- R1: `sum` equals the low four bits of A + B + cin, where A is `sw_opa`, B is `sw_opb` and cin is `sw_cin`, and the least significant bit of each vector is index 0.
- R2: `cout` is 1 exactly when A + B + cin is 16 or more.
- R3: A carry made at the lowest bit reaches `cout` through all four stages. For example, A=15, B=0, cin=1 gives sum 0 with cout 1, and A=8, B=7, cin=1 gives sum 0 with cout 1.
- R4: `seg` is active-low, with bit 6 driving segment g down to bit 0 driving segment a. It shows the sum as a hex glyph (0-9, A, b, C, d, E, F). Example codes: sum 0 gives 7'h40, sum 8 gives 7'h00, sum 11 gives 7'h03, and sum 15 gives 7'h0E.
- R5: `dp` is active-low and is 0 exactly when the carry-out of the addition is 1.
- R6: `an` is 4'b0111 for every input. Only bit 3, the leftmost digit, is enabled (active-low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sw_opb | input | 4 | Operand B, from switches 3..0 |
| sw_opa | input | 4 | Operand A, from switches 11..8 |
| sw_cin | input | 1 | Carry-in, from switch 15 |
| seg | output | 7 | Cathodes g..a, active-low |
| dp | output | 1 | Decimal point, active-low, lit on carry |
| an | output | 4 | Digit enables, active-low |
| sum | output | 4 | Raw 4-bit sum |
| cout | output | 1 | Raw carry-out |

## Verification
The hardest case to reach is a carry that must ripple through every stage. This happens when each bit position holds exactly one set operand bit and the carry-in is set, so a single low-order carry flips all four sum bits and emerges at the top. The sweep covers every operand and carry-in combination, which reaches all such propagate patterns. It also names a few of them explicitly, so a broken link in the chain shows up as a wrong sum and carry together.

// File: rtl/adder_hex_disp.sv
module adder_hex_disp #(
  parameter int W = 4
) (
  input  logic [W-1:0] sw_opb,
  input  logic [W-1:0] sw_opa,
  input  logic         sw_cin,
  output logic [6:0]   seg,
  output logic         dp,
  output logic [3:0]   an,
  output logic [W-1:0] sum,
  output logic         cout
);

  always_comb begin
    logic c;
    c = sw_cin;
    for (int i = 0; i < W; i++) begin
      sum[i] = sw_opa[i] ^ sw_opb[i] ^ c;
      c      = (sw_opa[i] & sw_opb[i]) | (c & (sw_opa[i] ^ sw_opb[i]));
    end
    cout = c;
  end

  always_comb begin
    unique case (sum[3:0])
      4'h0: seg = ~7'h3F;
      4'h1: seg = ~7'h06;
      4'h2: seg = ~7'h5B;
      4'h3: seg = ~7'h4F;
      4'h4: seg = ~7'h66;
      4'h5: seg = ~7'h6D;
      4'h6: seg = ~7'h7D;
      4'h7: seg = ~7'h07;
      4'h8: seg = ~7'h7F;
      4'h9: seg = ~7'h6F;
      4'hA: seg = ~7'h77;
      4'hB: seg = ~7'h7C;
      4'hC: seg = ~7'h39;
      4'hD: seg = ~7'h5E;
      4'hE: seg = ~7'h79;
      default: seg = ~7'h71;
    endcase
  end

  assign dp = ~cout;
  assign an = 4'b0111;

endmodule

module adder_hex_disp_chk (
  input logic [3:0] sw_opb,
  input logic [3:0] sw_opa,
  input logic       sw_cin,
  input logic [6:0] seg,
  input logic       dp,
  input logic [3:0] an,
  input logic [3:0] sum,
  input logic       cout
);
  logic [4:0] total;
  assign total = {1'b0, sw_opa} + {1'b0, sw_opb} + {4'b0, sw_cin};

  always_comb begin
    // R1 R2 R3
    sum_total_chk: assert ({cout, sum} == total);
    // R5
    dp_carry_chk: assert (dp == (total < 5'd16));
    // R6
    one_digit_chk: assert ($countones(an) == 3 && !an[3]);
    // R4
    glyph_lit_chk: assert (seg != 7'h7F);
    // R4
    eight_full_chk: assert ((sum != 4'h8) || (seg == 7'h00));
  end
endmodule

bind adder_hex_disp adder_hex_disp_chk chk_i (
  .sw_opb(sw_opb), .sw_opa(sw_opa), .sw_cin(sw_cin), .seg(seg),
  .dp(dp), .an(an), .sum(sum), .cout(cout)
);

// File: tb/tb_adder_hex_disp.sv
module tb_adder_hex_disp;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic [3:0] sw_opb, sw_opa, sum, an;
  logic       sw_cin, dp, cout;
  logic [6:0] seg;

  adder_hex_disp dut (
    .sw_opb(sw_opb), .sw_opa(sw_opa), .sw_cin(sw_cin), .seg(seg),
    .dp(dp), .an(an), .sum(sum), .cout(cout)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [6:0] glyph(input logic [3:0] v);
    logic [6:0] t [16] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78,
                           7'h00, 7'h10, 7'h08, 7'h03, 7'h46, 7'h21, 7'h06, 7'h0E};
    return t[v];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input int c);
    @(negedge clk);
    sw_opa = a[3:0]; sw_opb = b[3:0]; sw_cin = c[0];
    #1;
  endtask

  initial begin
    sw_opa = 0; sw_opb = 0; sw_cin = 0;
    @(negedge clk); #1;
    chk("R6 idle an", an, 4'b0111);
    chk("R4 idle seg", seg, 7'h40);
    chk("R5 idle dp", dp, 1);

    // R3 full ripple cases
    apply(15, 0, 1); chk("R3 sum", sum, 0); chk("R3 cout", cout, 1);
    apply(8, 7, 1);  chk("R3 sum", sum, 0); chk("R3 cout", cout, 1);
    apply(5, 10, 0); chk("R3 no-carry sum", sum, 15); chk("R3 no-carry cout", cout, 0);
    chk("R4 F glyph", seg, 7'h0E);
    apply(6, 5, 0);  chk("R4 b glyph", seg, 7'h03);

    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          int t;
          t = a + b + c;
          apply(a, b, c);
          chk("R1 sum", sum, t % 16);
          chk("R2 cout", cout, t / 16);
          chk("R4 seg", seg, glyph(t[3:0]));
          chk("R5 dp", dp, (t >= 16) ? 0 : 1);
          chk("R6 an", an, 4'b0111);
        end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule